// File: doc/BRIEF.md
# Interface Automatic Sleep Power Tracker

This block watches the host strobes of an asynchronous parallel memory interface: an active-low select, an active-low output enable, an active-low write enable and the address bus. From these it keeps a power level for the host interface: Active, AutoSleep or Standby. Dropping the select moves the interface to Standby at once. While the device stays selected and nothing changes, a stable-address counter runs. When that counter reaches its threshold the interface falls into AutoSleep. A second counter then times the dwell in AutoSleep, and when the dwell ends the level decays to Standby even though the select is still low.

A busy flag from the embedded algorithm controller gates a separate device-level indication. The whole device counts as standby only when the interface is at Standby and the controller is idle. The read datapath is outside this block. It only classifies power level, so the latched read data a host sees during sleep is not touched here. All pins are plain level signals sampled on the rising clock edge. There is no data stream, so there is no handshake.

Top module: `ifc_sleep_tracker`

## Requirements
- R1: After reset, `pwr_state` is Standby (2'b10) and both counters read 0.
- R2: A cycle in which `sel_n` is sampled high leaves, after that edge, `pwr_state` at Standby with `stable_cnt` and `dwell_cnt` both 0. Address and write-enable changes made while deselected have no effect.
- R3: With `sel_n` sampled low, an activity (a falling `sel_n`, or an address that differs from the previous sample) makes `pwr_state` Active (2'b00) with both counters cleared after that edge.
- R4: In Active with no activity, `stable_cnt` rises by one per cycle. In the cycle after it reads `SLEEP_CYC`, `pwr_state` becomes AutoSleep (2'b01).
- R5: AutoSleep entry timing does not depend on `oe_n`, which may toggle freely.
- R6: In AutoSleep, `dwell_cnt` rises by one per cycle. In the cycle after it reads `DWELL_CYC`, `pwr_state` becomes Standby while `sel_n` stays low, and the state holds there until the next activity.
- R7: `dev_standby` is 1 exactly when `pwr_state` is Standby and `alg_busy` is 0. It follows `alg_busy` in the same cycle.
- R8: `pwr_state` never takes the value 2'b11.
- R9: A falling edge of `we_n` while selected counts as activity: the state returns to Active and both counters clear. A rising edge of `we_n` does not.
- R10: `stable_cnt` saturates at `SLEEP_CYC` and `dwell_cnt` saturates at `DWELL_CYC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low device select |
| oe_n | input | 1 | Active-low output enable (observed, never affects power level) |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Host address bus |
| alg_busy | input | 1 | Embedded algorithm controller busy |
| pwr_state | output | 2 | 00 Active, 01 AutoSleep, 10 Standby |
| dev_standby | output | 1 | Whole device at standby level |
| stable_cnt | output | SC_W | Cycles of stable address while selected |
| dwell_cnt | output | DC_W | Cycles spent in AutoSleep |

## Verification
The bench goes after the exact threshold cycles. A design that is off by one at `SLEEP_CYC` or `DWELL_CYC` enters or leaves AutoSleep one cycle early or late. It drives `oe_n` wildly during the stable window, and a design that took output enable into account would delay sleep entry. It checks that only a falling `we_n` counts as activity, and that edges while deselected are ignored; a design that got this wrong would leave Standby or clear counters at the wrong time. It also holds the select low long past both thresholds to catch counters that wrap instead of saturating, and it toggles `alg_busy` while in Standby to catch a device-level indication that ignores the controller.

// File: rtl/ifc_pwr_pkg.sv
package ifc_pwr_pkg;
  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'b00,
    PWR_SLEEP  = 2'b01,
    PWR_STBY   = 2'b10
  } pwr_e;
endpackage

// File: rtl/ifc_act_det.sv
// Detects host activity: select falling, address change, write strobe falling.
module ifc_act_det #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              activity
);
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic              sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      we_q   <= 1'b1;
      sel_q  <= 1'b1;
    end else begin
      addr_q <= addr;
      we_q   <= we_n;
      sel_q  <= sel_n;
    end
  end

  logic sel_fall, addr_chg, we_fall;
  always_comb begin
    sel_fall = sel_q & ~sel_n;
    addr_chg = (addr != addr_q);
    we_fall  = we_q & ~we_n;
    activity = ~sel_n & (sel_fall | addr_chg | we_fall);
  end
endmodule

// File: rtl/ifc_sat_cnt.sv
// Saturating up-counter with synchronous clear.
module ifc_sat_cnt #(
  parameter int MAX = 8,
  localparam int W = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  always_comb at_max = (cnt == W'(MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (inc && !at_max)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ifc_pwr_fsm.sv
// Power level state machine.
module ifc_pwr_fsm
  import ifc_pwr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic activity,
  input  logic stable_max,
  input  logic dwell_max,
  output pwr_e state
);
  pwr_e state_nx;

  always_comb begin
    state_nx = state;
    if (sel_n)         state_nx = PWR_STBY;
    else if (activity) state_nx = PWR_ACTIVE;
    else begin
      unique case (state)
        PWR_ACTIVE: if (stable_max) state_nx = PWR_SLEEP;
        PWR_SLEEP:  if (dwell_max)  state_nx = PWR_STBY;
        PWR_STBY:   state_nx = PWR_STBY;
        default:    state_nx = PWR_STBY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PWR_STBY;
    else        state <= state_nx;
  end
endmodule

// File: rtl/ifc_sleep_tracker.sv
module ifc_sleep_tracker
  import ifc_pwr_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SLEEP_CYC = 8,
  parameter int DWELL_CYC = 12,
  localparam int SC_W = $clog2(SLEEP_CYC + 1),
  localparam int DC_W = $clog2(DWELL_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              alg_busy,
  output logic [1:0]        pwr_state,
  output logic              dev_standby,
  output logic [SC_W-1:0]   stable_cnt,
  output logic [DC_W-1:0]   dwell_cnt
);
  logic activity, stable_max, dwell_max, cnt_clr;
  pwr_e state;

  ifc_act_det #(.ADDR_W(ADDR_W)) act_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .we_n(we_n), .addr(addr),
    .activity(activity)
  );

  always_comb cnt_clr = sel_n | activity;

  ifc_sat_cnt #(.MAX(SLEEP_CYC)) stable_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(1'b1),
    .cnt(stable_cnt), .at_max(stable_max)
  );

  ifc_sat_cnt #(.MAX(DWELL_CYC)) dwell_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(state == PWR_SLEEP),
    .cnt(dwell_cnt), .at_max(dwell_max)
  );

  ifc_pwr_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .activity(activity),
    .stable_max(stable_max), .dwell_max(dwell_max), .state(state)
  );

  // output enable only gates data drive; it never shapes the power level
  logic oe_unused;
  always_comb oe_unused = oe_n;

  always_comb begin
    pwr_state   = state;
    dev_standby = (state == PWR_STBY) && !alg_busy;
  end
endmodule

// File: rtl/ifc_sleep_tracker_chk.sv
module ifc_sleep_tracker_chk #(
  parameter int ADDR_W    = 20,
  parameter int SLEEP_CYC = 8,
  parameter int DWELL_CYC = 12,
  localparam int SC_W = $clog2(SLEEP_CYC + 1),
  localparam int DC_W = $clog2(DWELL_CYC + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              alg_busy,
  input logic [1:0]        pwr_state,
  input logic              dev_standby,
  input logic [SC_W-1:0]   stable_cnt,
  input logic [DC_W-1:0]   dwell_cnt
);
  logic [ADDR_W-1:0] c_addr;
  logic c_we, c_sel, c_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_addr <= '0; c_we <= 1'b1; c_sel <= 1'b1;
    end else begin
      c_addr <= addr; c_we <= we_n; c_sel <= sel_n;
    end
  end
  always_comb c_act = !sel_n && ((c_sel && !sel_n) || (addr != c_addr) || (c_we && !we_n));

  a_r8_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'b11);

  a_r2_deselect_standby: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (pwr_state == 2'b10 && stable_cnt == '0 && dwell_cnt == '0));

  a_r3_activity_active: assert property (@(posedge clk) disable iff (!rst_n)
    c_act |=> (pwr_state == 2'b00 && stable_cnt == '0 && dwell_cnt == '0));

  a_r4_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00 && stable_cnt == SC_W'(SLEEP_CYC) && !sel_n && !c_act)
      |=> pwr_state == 2'b01);

  a_r6_dwell_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b01 && dwell_cnt == DC_W'(DWELL_CYC) && !sel_n && !c_act)
      |=> pwr_state == 2'b10);

  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    alg_busy |-> !dev_standby);

  a_r7_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b10 && !alg_busy) |-> dev_standby);

  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    stable_cnt <= SC_W'(SLEEP_CYC) && dwell_cnt <= DC_W'(DWELL_CYC));
endmodule

bind ifc_sleep_tracker ifc_sleep_tracker_chk #(
  .ADDR_W(ADDR_W), .SLEEP_CYC(SLEEP_CYC), .DWELL_CYC(DWELL_CYC)
) chk_i (.*);

// File: tb/ifc_sleep_tracker_tb_top.sv
module ifc_sleep_tracker_tb_top;
  localparam int AW = 20;
  localparam int S  = 8;
  localparam int D  = 12;
  localparam int SCW = $clog2(S + 1);
  localparam int DCW = $clog2(D + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, alg_busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0] pwr_state;
  logic dev_standby;
  logic [SCW-1:0] stable_cnt;
  logic [DCW-1:0] dwell_cnt;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ifc_sleep_tracker #(.ADDR_W(AW), .SLEEP_CYC(S), .DWELL_CYC(D)) dut_i (.*);

  // reference model written from the requirements
  int m_state, m_sc, m_dc;
  logic [AW-1:0] m_a;
  logic m_w, m_s;

  function automatic bit is_act(logic sn, logic ps, logic [AW-1:0] a,
                                logic [AW-1:0] pa, logic w, logic pw);
    return !sn && ((ps && !sn) || (a != pa) || (pw && !w));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 2; m_sc <= 0; m_dc <= 0; m_a <= '0; m_w <= 1'b1; m_s <= 1'b1;
    end else begin
      m_a <= addr; m_w <= we_n; m_s <= sel_n;
      if (sel_n) begin
        m_state <= 2; m_sc <= 0; m_dc <= 0;
      end else if (is_act(sel_n, m_s, addr, m_a, we_n, m_w)) begin
        m_state <= 0; m_sc <= 0; m_dc <= 0;
      end else begin
        m_sc <= (m_sc < S) ? m_sc + 1 : S;
        if (m_state == 1) m_dc <= (m_dc < D) ? m_dc + 1 : D;
        if (m_state == 0 && m_sc == S) m_state <= 1;
        if (m_state == 1 && m_dc == D) m_state <= 2;
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_model();
    chk(pwr_state == 2'(m_state), "R4/model state", pwr_state, m_state);
    chk(stable_cnt == SCW'(m_sc), "R10/model stable", stable_cnt, m_sc);
    chk(dwell_cnt == DCW'(m_dc), "R6/model dwell", dwell_cnt, m_dc);
    chk(dev_standby == (m_state == 2 && !alg_busy), "R7/model", dev_standby, m_state == 2 && !alg_busy);
    chk(pwr_state != 2'b11, "R8 legal", pwr_state, 0);
  endtask

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick(1);
    chk(pwr_state == 2'b10, "R1 reset state", pwr_state, 2);
    chk(stable_cnt == 0 && dwell_cnt == 0, "R1 reset counters", stable_cnt + dwell_cnt, 0);

    addr = 20'h123; sel_n = 1'b0;
    tick(1);
    chk(pwr_state == 2'b00 && stable_cnt == 0, "R3 select starts access", pwr_state, 0);
    tick(S);
    chk(pwr_state == 2'b00 && stable_cnt == S, "R4 at threshold still active", stable_cnt, S);
    tick(1);
    chk(pwr_state == 2'b01 && dwell_cnt == 0, "R4 enters sleep", pwr_state, 1);
    tick(D);
    chk(pwr_state == 2'b01 && dwell_cnt == D, "R6 dwell at limit", dwell_cnt, D);
    tick(1);
    chk(pwr_state == 2'b10, "R6 decays to standby while selected", pwr_state, 2);
    chk(dev_standby == 1'b1, "R7 idle standby", dev_standby, 1);
    alg_busy = 1'b1; #1;
    chk(dev_standby == 1'b0, "R7 busy blocks standby", dev_standby, 0);
    alg_busy = 1'b0;
    tick(5);
    chk(pwr_state == 2'b10 && stable_cnt == S && dwell_cnt == D, "R10 counters saturate", stable_cnt, S);

    addr = 20'h124;
    tick(1);
    chk(pwr_state == 2'b00 && stable_cnt == 0 && dwell_cnt == 0, "R3 address change", pwr_state, 0);
    for (int i = 0; i < S; i++) begin oe_n = ~oe_n; tick(1); end
    chk(pwr_state == 2'b00 && stable_cnt == S, "R5 oe toggling keeps count", stable_cnt, S);
    oe_n = ~oe_n; tick(1);
    chk(pwr_state == 2'b01, "R5 sleep despite oe", pwr_state, 1);
    oe_n = 1'b1;
    tick(2);
    we_n = 1'b0;
    tick(1);
    chk(pwr_state == 2'b00 && stable_cnt == 0 && dwell_cnt == 0, "R9 write fall is activity", pwr_state, 0);
    we_n = 1'b1;
    tick(1);
    chk(stable_cnt == 1, "R9 write rise not activity", stable_cnt, 1);

    sel_n = 1'b1;
    tick(1);
    chk(pwr_state == 2'b10 && stable_cnt == 0, "R2 deselect standby", pwr_state, 2);
    addr = addr + 1'b1; we_n = 1'b0;
    tick(1);
    chk(pwr_state == 2'b10 && stable_cnt == 0 && dwell_cnt == 0, "R2 ignored while deselected", pwr_state, 2);
    we_n = 1'b1;
    tick(1);

    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) sel_n = ~sel_n;
      else if (r < 6) addr = AW'($urandom_range(0, 7));
      else if (r < 9) we_n = ~we_n;
      oe_n = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 19) == 0) alg_busy = ~alg_busy;
      tick(1);
      chk_model();
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule